// File: doc/BRIEF.md
# Horizontal Timing RAM Loader

This block programs a 1024-slot horizontal timing memory that a separate scan engine reads once per pixel-clock slot. Each slot holds three control bits: blank, sync and half-line. The loader receives one of two commands. The start-up command writes a placeholder waveform, which keeps the scan engine producing line events before real timing is known. The load command builds a complete line waveform from three parameters: the line end address X, a packed word carrying the blank lead length W and the sync trail address A, and the trail length L. L is the distance from the sync trail to the blank trail.

The loader reaches the memory through one write port. An address write sets the memory's write pointer. Each data write that follows stores a code and advances the pointer by one, wrapping modulo 1024. Every waveform is produced as an ordered series of runs. A run is one address write followed by a number of data writes that all carry the same code. `busy` covers the whole series, and `done` pulses once it has finished.

The sequencer has four states. ST_IDLE moves to ST_ADDR when a request is accepted. ST_ADDR moves to ST_DATA when the current run has a non-zero length. Otherwise it moves on to the next run's ST_ADDR, or to ST_DONE after the last run. ST_DATA stays in place until the run's count is used up, then takes the same exit as ST_ADDR. ST_DONE returns to ST_IDLE after one cycle.

Top module: `hwave_loader`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `busy`, `done` and `ram_we` are all low.
- R2: Both commands first clear every slot. The first write of a command is an address write of 0, made in the cycle after the request is accepted, and it is followed by 1024 data writes of code 0.
- R3: The packed parameter word carries W in bits 15:8 and A in bits 7:0. X and L are 10-bit values. All parameters are captured when the request is accepted.
- R4: The load command writes the blank-only code 3'b001 (bit0 = blank) to slots X-W through X-1, with addresses taken modulo 1024.
- R5: The load command writes code 3'b001 to slots A through A+L-1, modulo 1024.
- R6: The load command writes the sync-and-blank code 3'b011 (bit1 = sync) to slot X.
- R7: The load command writes code 3'b011 to slots 0 through A-1.
- R8: The load command writes the half-line code 3'b100 (bit2 = half-line) to slots floor(X/2) through floor(X/2)+A-1, modulo 1024.
- R9: Load runs happen in this order: clear, R4, R5, R6, R7, R8. Where runs overlap, the later run's code is what remains.
- R10: The start-up command (`init_req`) clears the memory and then writes code 3'b001 to slots 0 through 39. If both requests are high in the same idle cycle, the start-up command wins.
- R11: Each run issues exactly one address write, whose data is the start address, followed by one data write per slot. A run of length zero issues no data writes. A load issues 6 address writes and 1024+W+L+1+2A data writes. A start-up command issues 2 address writes and 1064 data writes.
- R12: `busy` is high from the first clear write through the last write, and a write occurs in every busy cycle. `done` is high for exactly one cycle, the cycle after the last write. Requests that arrive while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_req | input | 1 | Start-up placeholder waveform request |
| load_req | input | 1 | Full waveform load request |
| max_addr | input | 10 | Line end address X |
| lead_sync_word | input | 16 | {W, A} packed parameter |
| trail_len | input | 10 | Sync trail to blank trail length L |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| ram_we | output | 1 | Write strobe to the timing memory |
| ram_is_addr | output | 1 | High: write sets the pointer; low: write stores data |
| ram_wdata | output | 10 | Address, or code in bits 2:0 |

## Verification
The bench models the memory at the write port and compares all 1024 slots against an image it rebuilds from the requirements. It runs six loads, each aimed at a different effect. A typical geometry shows that every run lands where it should. A lead run that wraps past slot 1023 separates modulo addressing from saturation. L = 0, and separately W = A = 0, show that empty runs leave no data writes behind. Fully overlapping runs with maximal W and A expose any error in run order. A line end at 1023 tests the top edge of the address range.

Directed cases cover reset, the start-up pattern, the case where both requests arrive together, and requests made while the block is busy. For each command, counting writes and busy cycles pins down where the `done` pulse falls.

// File: rtl/hwl_pkg.sv
package hwl_pkg;
    localparam int CODE_W    = 3;
    localparam int RUN_IDX_W = 3;

    typedef logic [CODE_W-1:0] code_t;

    localparam code_t CODE_ZERO       = 3'b000;
    localparam code_t CODE_BLANK      = 3'b001;
    localparam code_t CODE_SYNC_BLANK = 3'b011;
    localparam code_t CODE_HALF       = 3'b100;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_DONE
    } seq_state_t;
endpackage

// File: rtl/hwl_run_table.sv
module hwl_run_table
    import hwl_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int PW       = 8,
    parameter int INIT_LEN = 40,
    localparam int LEN_W   = ADDR_W + 1
) (
    input  logic                 mode_init,
    input  logic [RUN_IDX_W-1:0] run_idx,
    input  logic [ADDR_W-1:0]    x_addr,
    input  logic [PW-1:0]        w_len,
    input  logic [PW-1:0]        a_addr,
    input  logic [ADDR_W-1:0]    trail,
    output logic [ADDR_W-1:0]    run_start,
    output logic [LEN_W-1:0]     run_len,
    output code_t                run_code,
    output logic                 run_last
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(DEPTH);
    localparam logic [LEN_W-1:0] BOOT_LEN = LEN_W'(INIT_LEN);

    logic [ADDR_W-1:0] w_ext, a_ext;
    assign w_ext = ADDR_W'(w_len);
    assign a_ext = ADDR_W'(a_addr);

    always_comb begin
        run_start = '0;
        run_len   = '0;
        run_code  = CODE_ZERO;
        run_last  = 1'b0;
        if (mode_init) begin
            unique case (run_idx)
                3'd0: run_len = FULL_LEN;
                default: begin
                    run_len  = BOOT_LEN;
                    run_code = CODE_BLANK;
                    run_last = 1'b1;
                end
            endcase
        end else begin
            unique case (run_idx)
                3'd0: run_len = FULL_LEN;
                3'd1: begin
                    run_start = x_addr - w_ext;
                    run_len   = {1'b0, w_ext};
                    run_code  = CODE_BLANK;
                end
                3'd2: begin
                    run_start = a_ext;
                    run_len   = {1'b0, trail};
                    run_code  = CODE_BLANK;
                end
                3'd3: begin
                    run_start = x_addr;
                    run_len   = LEN_W'(1);
                    run_code  = CODE_SYNC_BLANK;
                end
                3'd4: begin
                    run_len  = {1'b0, a_ext};
                    run_code = CODE_SYNC_BLANK;
                end
                default: begin
                    run_start = x_addr >> 1;
                    run_len   = {1'b0, a_ext};
                    run_code  = CODE_HALF;
                    run_last  = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/hwl_seq.sv
module hwl_seq
    import hwl_pkg::*;
#(
    parameter int ADDR_W = 10,
    localparam int LEN_W = ADDR_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 go,
    input  logic [ADDR_W-1:0]    run_start,
    input  logic [LEN_W-1:0]     run_len,
    input  code_t                run_code,
    input  logic                 run_last,
    output logic [RUN_IDX_W-1:0] run_idx,
    output logic                 idle,
    output logic                 busy,
    output logic                 done,
    output logic                 ram_we,
    output logic                 ram_is_addr,
    output logic [ADDR_W-1:0]    ram_wdata
);
    seq_state_t           state_q, state_d;
    logic [RUN_IDX_W-1:0] run_q, run_d;
    logic [LEN_W-1:0]     cnt_q, cnt_d;
    logic                 run_over;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            run_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        run_d    = run_q;
        cnt_d    = cnt_q;
        run_over = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (go) begin
                    state_d = ST_ADDR;
                    run_d   = '0;
                    cnt_d   = '0;
                end
            end
            ST_ADDR: begin
                cnt_d = '0;
                if (run_len == '0) run_over = 1'b1;
                else               state_d  = ST_DATA;
            end
            ST_DATA: begin
                if (cnt_q == run_len - 1'b1) run_over = 1'b1;
                else                         cnt_d    = cnt_q + 1'b1;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
        if (run_over) begin
            if (run_last) begin
                state_d = ST_DONE;
            end else begin
                state_d = ST_ADDR;
                run_d   = run_q + 1'b1;
            end
        end
    end

    always_comb begin
        idle        = (state_q == ST_IDLE);
        busy        = (state_q == ST_ADDR) || (state_q == ST_DATA);
        done        = (state_q == ST_DONE);
        ram_we      = busy;
        ram_is_addr = (state_q == ST_ADDR);
        ram_wdata   = ram_is_addr ? run_start
                                  : {{(ADDR_W-CODE_W){1'b0}}, run_code};
        run_idx     = run_q;
    end
endmodule

// File: rtl/hwave_loader.sv
module hwave_loader
    import hwl_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int PW       = 8,
    parameter int INIT_LEN = 40,
    localparam int LEN_W   = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_req,
    input  logic              load_req,
    input  logic [ADDR_W-1:0] max_addr,
    input  logic [2*PW-1:0]   lead_sync_word,
    input  logic [ADDR_W-1:0] trail_len,
    output logic              busy,
    output logic              done,
    output logic              ram_we,
    output logic              ram_is_addr,
    output logic [ADDR_W-1:0] ram_wdata
);
    logic                 idle, accept;
    logic                 mode_init_q;
    logic [ADDR_W-1:0]    x_q, trail_q;
    logic [PW-1:0]        w_q, a_q;
    logic [RUN_IDX_W-1:0] run_idx;
    logic [ADDR_W-1:0]    run_start;
    logic [LEN_W-1:0]     run_len;
    code_t                run_code;
    logic                 run_last;

    assign accept = idle && (init_req || load_req);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_init_q <= 1'b0;
            x_q         <= '0;
            w_q         <= '0;
            a_q         <= '0;
            trail_q     <= '0;
        end else if (accept) begin
            mode_init_q <= init_req;
            x_q         <= max_addr;
            w_q         <= lead_sync_word[2*PW-1:PW];
            a_q         <= lead_sync_word[PW-1:0];
            trail_q     <= trail_len;
        end
    end

    hwl_run_table #(.ADDR_W(ADDR_W), .PW(PW), .INIT_LEN(INIT_LEN)) table_i (
        .mode_init (mode_init_q),
        .run_idx   (run_idx),
        .x_addr    (x_q),
        .w_len     (w_q),
        .a_addr    (a_q),
        .trail     (trail_q),
        .run_start (run_start),
        .run_len   (run_len),
        .run_code  (run_code),
        .run_last  (run_last)
    );

    hwl_seq #(.ADDR_W(ADDR_W)) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .go          (accept),
        .run_start   (run_start),
        .run_len     (run_len),
        .run_code    (run_code),
        .run_last    (run_last),
        .run_idx     (run_idx),
        .idle        (idle),
        .busy        (busy),
        .done        (done),
        .ram_we      (ram_we),
        .ram_is_addr (ram_is_addr),
        .ram_wdata   (ram_wdata)
    );
endmodule

// File: rtl/hwl_checker.sv
module hwl_checker #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              ram_we,
    input logic              ram_is_addr,
    input logic [ADDR_W-1:0] ram_wdata
);
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ram_we); // R11
    AST_DATA_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && !ram_is_addr) |-> $past(ram_we)); // R11
    AST_WRITE_EACH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ram_we); // R12
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12
    AST_DONE_AFTER_WORK: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R12
    AST_CLEAR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (ram_is_addr && ram_wdata == '0)); // R2
    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && !ram_is_addr) |-> (ram_wdata <= 4 && ram_wdata != 2)); // R9
endmodule

bind hwave_loader hwl_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .ram_we      (ram_we),
    .ram_is_addr (ram_is_addr),
    .ram_wdata   (ram_wdata)
);

// File: tb/hwave_loader_tb_top.sv
`timescale 1ns/1ps
module hwave_loader_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       init_req = 1'b0, load_req = 1'b0;
    logic [9:0] max_addr = '0, trail_len = '0;
    logic [15:0] lead_sync_word = '0;
    logic       busy, done, ram_we, ram_is_addr;
    logic [9:0] ram_wdata;

    int checks = 0, failures = 0;
    int cycles = 0;
    logic [2:0] mem [1024];
    logic [2:0] expm [1024];
    int  ptr = 0, n_addr = 0, n_data = 0;
    logic scramble = 1'b0;

    always #2 clk = ~clk;

    hwave_loader dut_i (
        .clk(clk), .rst_n(rst_n), .init_req(init_req), .load_req(load_req),
        .max_addr(max_addr), .lead_sync_word(lead_sync_word), .trail_len(trail_len),
        .busy(busy), .done(done), .ram_we(ram_we), .ram_is_addr(ram_is_addr),
        .ram_wdata(ram_wdata)
    );

    // memory model of the write port (R11 protocol)
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (scramble) begin
            for (int i = 0; i < 1024; i++) mem[i] <= 3'b111;
            n_addr <= 0;
            n_data <= 0;
        end else if (rst_n && ram_we) begin
            if (ram_is_addr) begin
                ptr    <= int'(ram_wdata);
                n_addr <= n_addr + 1;
            end else begin
                mem[ptr] <= ram_wdata[2:0];
                ptr      <= (ptr + 1) % 1024;
                n_data   <= n_data + 1;
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            if (cycles > 150000) begin
                failures++;
                $display("FAIL watchdog: run hung (actual cycles=%0d, expected < 150000)", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic fill(input int s, input int len, input logic [2:0] code);
        for (int k = 0; k < len; k++) expm[(s + k) % 1024] = code;
    endtask

    task automatic build_exp(input bit boot, input int x, input int w,
                             input int a, input int l);
        fill(0, 1024, 3'b000);
        if (boot) begin
            fill(0, 40, 3'b001);
        end else begin
            fill((x - w + 1024) % 1024, w, 3'b001);
            fill(a, l, 3'b001);
            fill(x, 1, 3'b011);
            fill(0, a, 3'b011);
            fill(x / 2, a, 3'b100);
        end
    endtask

    task automatic run_cmd(input bit di, input bit dl, input int x, input int w,
                           input int a, input int l, input bit interfere,
                           input string tag);
        int  n, bad, first, exp_a, exp_d;
        bit  boot;
        boot = di;
        build_exp(boot, x, w, a, l);
        exp_a = boot ? 2 : 6;
        exp_d = boot ? 1064 : 1024 + w + l + 1 + 2 * a;
        @(negedge clk); scramble = 1'b1;
        @(negedge clk); scramble = 1'b0;
        init_req = di; load_req = dl;
        max_addr = 10'(x); lead_sync_word = {8'(w), 8'(a)}; trail_len = 10'(l);
        @(negedge clk);
        init_req = 1'b0; load_req = 1'b0;
        check(busy && ram_we && ram_is_addr && ram_wdata == 10'd0, "R2",
              {tag, " first write is address 0"}, int'(ram_wdata), 0);
        n = 0;
        while (busy) begin
            n++;
            if (interfere && n == 50) begin
                init_req = 1'b1; load_req = 1'b1;
                max_addr = 10'd3; lead_sync_word = 16'hFFFF; trail_len = 10'd999;
            end else if (interfere && n == 51) begin
                init_req = 1'b0; load_req = 1'b0;
            end
            @(negedge clk);
        end
        check(done === 1'b1, "R12", {tag, " done after last write"}, int'(done), 1);
        check(n == exp_a + exp_d, "R12", {tag, " busy cycles"}, n, exp_a + exp_d);
        check(n_addr == exp_a && n_data == exp_d, "R11", {tag, " address/data write counts"},
              n_addr * 10000 + n_data, exp_a * 10000 + exp_d);
        @(negedge clk);
        check(done === 1'b0 && busy === 1'b0, "R12", {tag, " done one cycle"}, int'(done), 0);
        bad = 0; first = -1;
        for (int i = 0; i < 1024; i++)
            if (mem[i] !== expm[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        if (first >= 0)
            $display("FAIL %s first bad slot %0d: actual=%0d expected=%0d",
                     tag, first, mem[first], expm[first]);
        check(bad == 0,
              boot ? "R10 R2" : "R2 R3 R4 R5 R6 R7 R8 R9",
              {tag, " memory image mismatching slots"}, bad, 0);
    endtask

    // {X[35:26], W[25:18], A[17:10], L[9:0]}
    localparam logic [35:0] VECS [6] = '{
        {10'd799,  8'd100, 8'd60,  10'd40},   // typical line
        {10'd5,    8'd10,  8'd3,   10'd2},    // lead run wraps below 0
        {10'd600,  8'd50,  8'd20,  10'd0},    // L = 0
        {10'd300,  8'd0,   8'd0,   10'd7},    // W = A = 0
        {10'd100,  8'd255, 8'd255, 10'd300},  // heavy overlap, order matters
        {10'd1023, 8'd1,   8'd200, 10'd823}   // line end at top slot
    };

    initial begin
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && ram_we === 1'b0, "R1",
              "outputs in reset", int'(busy) + int'(done) + int'(ram_we), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && ram_we === 1'b0, "R1",
              "outputs after reset", int'(busy) + int'(done) + int'(ram_we), 0);

        for (int v = 0; v < 6; v++) begin
            logic [35:0] e;
            e = VECS[v];
            run_cmd(1'b0, 1'b1, int'(e[35:26]), int'(e[25:18]), int'(e[17:10]),
                    int'(e[9:0]), v == 1, $sformatf("load vec%0d", v));
        end

        // R10: start-up pattern
        run_cmd(1'b1, 1'b0, 0, 0, 0, 0, 1'b0, "R10 init");
        // R10: both requests together, start-up command wins
        run_cmd(1'b1, 1'b1, 700, 30, 40, 50, 1'b0, "R10 both requests");
        // R12: a load with requests during busy keeps its own parameters
        run_cmd(1'b0, 1'b1, 512, 64, 16, 32, 1'b1, "R12 ignore while busy");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule